// File: doc/BRIEF.md
# Ray Packet Traversal Mask Controller

This block steers a packet of 64 coherent rays through a binary space partition tree. It holds one active-ray mask for the branch being walked. For every inner node it receives the child addresses and two per-ray hit vectors from an external plane-test datapath. From these it computes a mask for each child. It descends into the near child first and defers the far child on a mask stack. A child that no active ray reaches is never fetched.

At a leaf, the block hands the triangle-list address and the current mask to a list unit. It then waits for that unit's per-ray hit report. Rays that report a hit are retired from the packet. Retired rays are stripped from every later mask, including branches already deferred on the stack. The packet finishes in one of two ways: the stack runs dry, or every ray of the packet is retired. In both cases the block pulses a done strobe carrying the retired-ray set back to the ray owner.

Top module: `pkt_trav_ctrl`

## Requirements
- R1: A packet is accepted only while `start_ready` is high, which is only in the idle state. A `start_valid` seen while a packet is in progress is ignored.
- R2: A node request keeps `nreq_valid` high and `nreq_addr` unchanged until `nreq_ready` is seen high.
- R3: For an inner node, near mask = current mask AND `nrsp_near_hit` AND NOT retired, and far mask is formed the same way from `nrsp_far_hit`. When both are nonzero, the near child is requested next and the far child (address and mask) is deferred.
- R4: A child whose mask is all zero is never requested. A leaf is never offered with an empty mask.
- R5: At a leaf (`nrsp_is_leaf` = 1), `leaf_valid` is raised with `leaf_addr` = `nrsp_list_addr` and `leaf_mask` = current mask. Both are held until `leaf_ready`.
- R6: After a leaf hand-off, the block waits for `lres_valid`. Bits of `lres_hit` that fall inside the leaf mask retire those rays, and retired rays are absent from every later request mask and leaf mask.
- R7: A deferred branch whose mask becomes zero after removing retired rays is discarded without a request.
- R8: Deferred branches are resumed last-in first-out.
- R9: `done_valid` pulses for exactly one cycle when the stack is empty and no branch is pending, or at once when every ray of the packet is retired, even with branches still deferred. `done_hits` then carries the retired set.
- R10: After reset the block is idle, with `start_ready` = 1 and no request, leaf or done strobe.
- R11: A packet started with an all-zero mask completes with `done_hits` = 0 and no node request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | New packet offered |
| start_ready | output | 1 | Block idle, packet can be taken |
| start_addr | input | 32 | Root node address of the packet |
| start_mask | input | 64 | Initial active rays |
| nreq_valid | output | 1 | Node fetch request |
| nreq_ready | input | 1 | Node fetch accepted |
| nreq_addr | output | 32 | Node address to fetch |
| nrsp_valid | input | 1 | Node data and hit vectors present |
| nrsp_is_leaf | input | 1 | Fetched node is a leaf |
| nrsp_near_addr | input | 32 | Near child address |
| nrsp_far_addr | input | 32 | Far child address |
| nrsp_list_addr | input | 32 | Triangle-list address of a leaf |
| nrsp_near_hit | input | 64 | Per-ray near-child test result |
| nrsp_far_hit | input | 64 | Per-ray far-child test result |
| leaf_valid | output | 1 | Leaf work offered to list unit |
| leaf_ready | input | 1 | List unit accepts leaf work |
| leaf_addr | output | 32 | Triangle-list address |
| leaf_mask | output | 64 | Rays to intersect at this leaf |
| lres_valid | input | 1 | List unit result present |
| lres_hit | input | 64 | Rays that found a hit in the leaf |
| done_valid | output | 1 | One-cycle packet completion strobe |
| done_hits | output | 64 | Rays retired by a hit |

## Verification
Two functions can fall in the same cycle. The first is the retirement update from a list result. The second is the completion decision, which has to see the updated set: retiring the last live ray must end the packet even though branches remain deferred. A packet whose leaves report hits for every ray provokes this, with deferred far branches still on the stack. Further packets with sparse hits exercise the later case, where a popped branch loses all its rays to retirement and must be dropped without a fetch. The scoreboard judges both against a behavioural walk of the same tree: any surplus request, missing request or wrong leaf mask shows up as a mismatch in the expected event order.

// File: rtl/trav_pkg.sv
package trav_pkg;
    localparam int RAYS = 64;
    localparam int AW   = 32;

    typedef logic [RAYS-1:0] rmask_t;
    typedef logic [AW-1:0]   naddr_t;

    typedef struct packed {
        naddr_t addr;
        rmask_t mask;
    } branch_t;

    typedef enum logic [2:0] {
        S_IDLE, S_REQ, S_WAIT, S_LEAF, S_LWAIT, S_POP, S_DONE
    } st_e;
endpackage

// File: rtl/trav_child_sel.sv
module trav_child_sel
    import trav_pkg::*;
(
    input  rmask_t cur_mask,
    input  rmask_t near_hit,
    input  rmask_t far_hit,
    input  rmask_t retired,
    output rmask_t near_mask,
    output rmask_t far_mask,
    output logic   near_any,
    output logic   far_any
);
    rmask_t live;

    always_comb begin
        live      = cur_mask & ~retired;
        near_mask = live & near_hit;
        far_mask  = live & far_hit;
        near_any  = |near_mask;
        far_any   = |far_mask;
    end
endmodule

// File: rtl/trav_mask_stack.sv
module trav_mask_stack
    import trav_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    push,
    input  logic    pop,
    input  branch_t push_ent,
    output branch_t top_ent,
    output logic    empty,
    output logic    full
);
    localparam int PW = $clog2(DEPTH + 1);

    branch_t       mem_q [DEPTH];
    logic [PW-1:0] sp_d, sp_q;

    always_comb begin
        sp_d = sp_q;
        if (push && !full)      sp_d = sp_q + 1'b1;
        else if (pop && !empty) sp_d = sp_q - 1'b1;
        empty   = (sp_q == '0);
        full    = (sp_q == PW'(DEPTH));
        top_ent = empty ? '0 : mem_q[sp_q - 1'b1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sp_q <= '0;
        else        sp_q <= sp_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && !full && sp_q == PW'(i)) mem_q[i] <= push_ent;
        end
    end
endmodule

// File: rtl/pkt_trav_ctrl.sv
module pkt_trav_ctrl
    import trav_pkg::*;
#(
    parameter int STACK_DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_valid,
    output logic                       start_ready,
    input  logic [trav_pkg::AW-1:0]    start_addr,
    input  logic [trav_pkg::RAYS-1:0]  start_mask,
    output logic                       nreq_valid,
    input  logic                       nreq_ready,
    output logic [trav_pkg::AW-1:0]    nreq_addr,
    input  logic                       nrsp_valid,
    input  logic                       nrsp_is_leaf,
    input  logic [trav_pkg::AW-1:0]    nrsp_near_addr,
    input  logic [trav_pkg::AW-1:0]    nrsp_far_addr,
    input  logic [trav_pkg::AW-1:0]    nrsp_list_addr,
    input  logic [trav_pkg::RAYS-1:0]  nrsp_near_hit,
    input  logic [trav_pkg::RAYS-1:0]  nrsp_far_hit,
    output logic                       leaf_valid,
    input  logic                       leaf_ready,
    output logic [trav_pkg::AW-1:0]    leaf_addr,
    output logic [trav_pkg::RAYS-1:0]  leaf_mask,
    input  logic                       lres_valid,
    input  logic [trav_pkg::RAYS-1:0]  lres_hit,
    output logic                       done_valid,
    output logic [trav_pkg::RAYS-1:0]  done_hits
);
    typedef struct packed {
        st_e    st;
        naddr_t addr;
        rmask_t mask;
        rmask_t pkt;
        rmask_t hits;
    } ctl_t;

    ctl_t    ctl_d, ctl_q;
    logic    push, pop, stk_empty, stk_full;
    branch_t push_ent, top_ent;
    rmask_t  near_mask, far_mask, new_hits, pop_mask;
    logic    near_any, far_any;
    rmask_t  retired_q;

    assign retired_q = ctl_q.hits;

    trav_child_sel u_sel (
        .cur_mask  (ctl_q.mask),
        .near_hit  (nrsp_near_hit),
        .far_hit   (nrsp_far_hit),
        .retired   (ctl_q.hits),
        .near_mask (near_mask),
        .far_mask  (far_mask),
        .near_any  (near_any),
        .far_any   (far_any)
    );

    trav_mask_stack #(.DEPTH(STACK_DEPTH)) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .push_ent (push_ent),
        .top_ent  (top_ent),
        .empty    (stk_empty),
        .full     (stk_full)
    );

    always_comb begin
        ctl_d       = ctl_q;
        push        = 1'b0;
        pop         = 1'b0;
        push_ent    = '0;
        start_ready = 1'b0;
        nreq_valid  = 1'b0;
        leaf_valid  = 1'b0;
        done_valid  = 1'b0;
        new_hits    = ctl_q.hits | (lres_hit & ctl_q.mask);
        pop_mask    = top_ent.mask & ~ctl_q.hits;

        unique case (ctl_q.st)
            S_IDLE: begin
                start_ready = 1'b1;
                if (start_valid) begin
                    ctl_d.addr = start_addr;
                    ctl_d.mask = start_mask;
                    ctl_d.pkt  = start_mask;
                    ctl_d.hits = '0;
                    ctl_d.st   = (start_mask == '0) ? S_DONE : S_REQ;
                end
            end
            S_REQ: begin
                nreq_valid = 1'b1;
                if (nreq_ready) ctl_d.st = S_WAIT;
            end
            S_WAIT: begin
                if (nrsp_valid) begin
                    if (nrsp_is_leaf) begin
                        ctl_d.addr = nrsp_list_addr;
                        ctl_d.st   = S_LEAF;
                    end else if (near_any) begin
                        ctl_d.addr    = nrsp_near_addr;
                        ctl_d.mask    = near_mask;
                        ctl_d.st      = S_REQ;
                        push          = far_any;
                        push_ent.addr = nrsp_far_addr;
                        push_ent.mask = far_mask;
                    end else if (far_any) begin
                        ctl_d.addr = nrsp_far_addr;
                        ctl_d.mask = far_mask;
                        ctl_d.st   = S_REQ;
                    end else begin
                        ctl_d.st = S_POP;
                    end
                end
            end
            S_LEAF: begin
                leaf_valid = 1'b1;
                if (leaf_ready) ctl_d.st = S_LWAIT;
            end
            S_LWAIT: begin
                if (lres_valid) begin
                    ctl_d.hits = new_hits;
                    ctl_d.st   = ((ctl_q.pkt & ~new_hits) == '0) ? S_DONE : S_POP;
                end
            end
            S_POP: begin
                if (stk_empty) begin
                    ctl_d.st = S_DONE;
                end else begin
                    pop = 1'b1;
                    if (pop_mask != '0) begin
                        ctl_d.addr = top_ent.addr;
                        ctl_d.mask = pop_mask;
                        ctl_d.st   = S_REQ;
                    end
                end
            end
            S_DONE: begin
                done_valid = 1'b1;
                ctl_d.st   = S_IDLE;
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= S_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign nreq_addr = ctl_q.addr;
    assign leaf_addr = ctl_q.addr;
    assign leaf_mask = ctl_q.mask;
    assign done_hits = ctl_q.hits;
endmodule

// File: rtl/pkt_trav_chk.sv
module pkt_trav_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_ready,
    input logic        nreq_valid,
    input logic        nreq_ready,
    input logic [31:0] nreq_addr,
    input logic        leaf_valid,
    input logic        leaf_ready,
    input logic [31:0] leaf_addr,
    input logic [63:0] leaf_mask,
    input logic        done_valid,
    input logic [63:0] hits
);
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        nreq_valid && !nreq_ready |=> nreq_valid && $stable(nreq_addr));

    assert_leaf_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        leaf_valid && !leaf_ready |=> leaf_valid && $stable(leaf_addr) && $stable(leaf_mask));

    assert_leaf_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        leaf_valid |-> leaf_mask != '0);

    assert_leaf_no_retired_R6: assert property (@(posedge clk) disable iff (!rst_n)
        leaf_valid |-> (leaf_mask & hits) == '0);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nreq_valid, leaf_valid, done_valid}));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_ready |-> !nreq_valid && !leaf_valid);
endmodule

bind pkt_trav_ctrl pkt_trav_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_ready (start_ready),
    .nreq_valid  (nreq_valid),
    .nreq_ready  (nreq_ready),
    .nreq_addr   (nreq_addr),
    .leaf_valid  (leaf_valid),
    .leaf_ready  (leaf_ready),
    .leaf_addr   (leaf_addr),
    .leaf_mask   (leaf_mask),
    .done_valid  (done_valid),
    .hits        (retired_q)
);

// File: tb/pkt_trav_ctrl_tb.sv
module pkt_trav_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0, start_ready;
    logic [31:0] start_addr = '0;
    logic [63:0] start_mask = '0;
    logic        nreq_valid, nreq_ready = 1'b1;
    logic [31:0] nreq_addr;
    logic        nrsp_valid = 1'b0, nrsp_is_leaf = 1'b0;
    logic [31:0] nrsp_near_addr = '0, nrsp_far_addr = '0, nrsp_list_addr = '0;
    logic [63:0] nrsp_near_hit = '0, nrsp_far_hit = '0;
    logic        leaf_valid, leaf_ready = 1'b1;
    logic [31:0] leaf_addr;
    logic [63:0] leaf_mask;
    logic        lres_valid = 1'b0;
    logic [63:0] lres_hit = '0;
    logic        done_valid;
    logic [63:0] done_hits;

    always #10 clk = ~clk;

    pkt_trav_ctrl u_dut (.*);

    typedef struct { int kind; logic [31:0] addr; logic [63:0] mask; } ev_t;
    ev_t expq[$];

    int errors = 0, checks = 0, done_seen = 0, cyc = 0;
    int stall = 0, lpct = 20;

    function automatic logic hb(int a, int r, int k, int pct);
        logic [31:0] x;
        x = 32'(a) * 32'd7919 + 32'(r) * 32'd104729 + 32'(k) * 32'd15485863;
        x = x ^ (x >> 13);
        x = x * 32'h5bd1e995;
        x = x ^ (x >> 15);
        return (x % 100) < 32'(pct);
    endfunction

    function automatic logic [63:0] hvec(int a, int k, int pct);
        logic [63:0] v;
        for (int r = 0; r < 64; r++) v[r] = hb(a, r, k, pct);
        return v;
    endfunction

    function automatic int near_of(int a); return 2 * a + (a % 2); endfunction
    function automatic int far_of(int a);  return 2 * a + 1 - (a % 2); endfunction
    function automatic int list_of(int a); return 4096 + a * 16; endfunction

    function automatic void push_ev(int k, logic [31:0] a, logic [63:0] m);
        ev_t e;
        e.kind = k; e.addr = a; e.mask = m;
        expq.push_back(e);
    endfunction

    // behavioural walk of the tree: kind 0 request, 1 leaf, 2 done
    function automatic void model(int root, logic [63:0] m0);
        int          sa[$];
        logic [63:0] sm[$];
        logic [63:0] ret = '0, cm, nm, fm;
        int          ca;
        logic        walking;
        if (m0 == '0) begin push_ev(2, 0, '0); return; end
        ca = root; cm = m0; walking = 1'b1;
        while (1) begin
            if (walking) begin
                push_ev(0, ca, 0);
                if (ca >= 16) begin
                    push_ev(1, list_of(ca), cm);
                    ret |= hvec(ca, 2, lpct) & cm;
                    if ((m0 & ~ret) == '0) begin push_ev(2, 0, ret); return; end
                    walking = 1'b0;
                end else begin
                    nm = cm & hvec(ca, 0, 70) & ~ret;
                    fm = cm & hvec(ca, 1, 45) & ~ret;
                    if (nm != '0) begin
                        if (fm != '0) begin sa.push_back(far_of(ca)); sm.push_back(fm); end
                        ca = near_of(ca); cm = nm;
                    end else if (fm != '0) begin
                        ca = far_of(ca); cm = fm;
                    end else walking = 1'b0;
                end
            end else begin
                if (sa.size() == 0) begin push_ev(2, 0, ret); return; end
                ca = sa.pop_back(); cm = sm.pop_back() & ~ret;
                if (cm != '0) walking = 1'b1;
            end
        end
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic take(input int k, input logic [31:0] a, input logic [63:0] m);
        ev_t e;
        if (expq.size() == 0) begin
            chk(1'b0, "R4 R7 unexpected event", 64'(a), 64'(k + 100));
            return;
        end
        e = expq.pop_front();
        if (k == 0)      chk(e.kind == 0 && e.addr == a, "R3 R4 R7 R8 request order", 64'(a), 64'(e.addr));
        else if (k == 1) chk(e.kind == 1 && e.addr == a && e.mask == m, "R5 R6 leaf mask", m, e.mask);
        else             chk(e.kind == 2 && e.mask == m, "R9 done hits", m, e.mask);
    endtask

    // monitor + responders
    initial begin
        int          pn = 0, na = 0, nc = 0, pl = 0, la = 0, lc = 0;
        logic        pv = 1'b0, pr = 1'b0;
        logic [31:0] pa = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++; checks++;
                $display("FAIL watchdog actual=%0d expected=done", cyc);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
            if (rst_n && pv && !pr)
                chk(nreq_valid && nreq_addr == pa, "R2 request held", 64'(nreq_addr), 64'(pa));
            pv = nreq_valid; pr = nreq_ready; pa = nreq_addr;
            if (nreq_valid && nreq_ready) begin
                take(0, nreq_addr, '0);
                pn = 1; na = int'(nreq_addr); nc = na % 3;
            end
            if (leaf_valid && leaf_ready) begin
                take(1, leaf_addr, leaf_mask);
                pl = 1; la = (int'(leaf_addr) - 4096) / 16; lc = 1;
            end
            if (done_valid) begin
                take(2, 0, done_hits);
                done_seen++;
            end
            @(posedge clk); #1;
            nrsp_valid = 1'b0; lres_valid = 1'b0;
            if (pn != 0) begin
                if (nc == 0) begin
                    pn = 0;
                    nrsp_valid     = 1'b1;
                    nrsp_is_leaf   = (na >= 16);
                    nrsp_near_addr = 32'(near_of(na));
                    nrsp_far_addr  = 32'(far_of(na));
                    nrsp_list_addr = 32'(list_of(na));
                    nrsp_near_hit  = hvec(na, 0, 70);
                    nrsp_far_hit   = hvec(na, 1, 45);
                end else nc--;
            end
            if (pl != 0) begin
                if (lc == 0) begin
                    pl = 0; lres_valid = 1'b1; lres_hit = hvec(la, 2, lpct);
                end else lc--;
            end
            nreq_ready = (stall != 0) ? ((cyc % 3) != 0) : 1'b1;
            leaf_ready = (stall != 0) ? ((cyc % 4) >= 2) : 1'b1;
        end
    end

    task automatic run_pkt(input int root, input logic [63:0] m, input int st, input int lp, input int busy_poke);
        int target;
        stall = st; lpct = lp;
        model(root, m);
        target = done_seen + 1;
        @(posedge clk); #1;
        start_valid = 1'b1; start_addr = 32'(root); start_mask = m;
        @(posedge clk); #1;
        if (busy_poke != 0) begin
            start_addr = 32'd3; start_mask = '1;   // R1: must be ignored while busy
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                chk(start_ready == 1'b0, "R1 ready low while busy", 64'(start_ready), 64'd0);
            end
            @(posedge clk); #1;
        end
        start_valid = 1'b0;
        while (done_seen < target) @(posedge clk);
        @(negedge clk);
        chk(expq.size() == 0, "R9 all expected events seen", 64'(expq.size()), 64'd0);
        chk(start_ready == 1'b1, "R1 idle after done", 64'(start_ready), 64'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(start_ready == 1'b1, "R10 reset start_ready", 64'(start_ready), 64'd1);
        chk({nreq_valid, leaf_valid, done_valid} == 3'b0, "R10 reset strobes", 64'({nreq_valid, leaf_valid, done_valid}), 64'd0);
        rst_n = 1'b1;
        run_pkt(1, '1, 0, 20, 0);                         // R3 R8 dense packet
        run_pkt(1, 64'h00F0_0000_0000_0F01, 1, 20, 1);    // R1 R2 R5 sparse, stalls
        run_pkt(1, 64'h1 << 37, 1, 30, 0);                // R4 single ray
        run_pkt(1, '0, 0, 20, 0);                         // R11 empty packet
        run_pkt(1, '1, 1, 100, 0);                        // R9 early done, stack nonempty
        run_pkt(6, 64'hAAAA_5555_AAAA_5555, 1, 40, 0);    // R6 R7 retire prunes deferred
        run_pkt(2, 64'hFFFF_0000_0000_FFFF, 0, 60, 0);    // R6 R7 heavy retirement
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule